// File: doc/BRIEF.md
# Serial Byte-Stream to Bus Bridge

This block turns a stream of received bytes into 32-bit bus master cycles. It sits between a byte-wide receive/transmit stream pair and a bus master port with a cycle/strobe/acknowledge handshake. Both byte streams use valid/ready, and a byte moves on any clock edge where both are high. A host sends framed commands. A write command moves a burst of 32-bit words from the serial side onto consecutive bus word addresses. A read command fetches a burst of words and streams them back as bytes.

A frame opens with a command byte. Next comes a one-byte word count, then a 32-bit word address in four bytes, most significant byte first. A write frame then carries its data words, each as four bytes with the most significant byte first and no gap between words. A read frame ends after the address, and the bridge answers with the requested words in the same byte order. The bridge never sends any bytes in reply to a write.

Top module: `serbus_bridge`

## Requirements
- R1: In the idle state, a received byte of 0x01 starts a write frame and 0x02 starts a read frame. Any other byte is consumed and dropped, and the bridge stays idle waiting for the next command byte.
- R2: After the command byte, one byte gives the word count N. The next four bytes form the word address, most significant byte first. The address appears unchanged on `busAdr` in the first bus cycle.
- R3: In a write frame, each data word arrives as four bytes, most significant byte first. Its bus cycle starts only after the fourth byte, with `busWe`=1, `busSel`=4'b1111 and the assembled word on `busDatW`.
- R4: Bus cycle k of a burst, counting from 0, uses word address base+k. Exactly N cycles are run.
- R5: In a read frame, each word returned by the bus is sent on the transmit stream as four bytes, most significant byte first, with `busWe`=0.
- R6: In a read frame, the bus cycle for the next word starts only after all four bytes of the current word have been accepted. While `txReady` is low, `txValid` stays high and `txData` does not change, so no byte is lost.
- R7: Once raised, `busStb` holds its address, data and write flag until `busAck`. It drops in the cycle after the acknowledge. No receive byte is accepted while a bus cycle is open.
- R8: A word count of zero completes the frame after the address with no bus cycle and no transmitted byte, and the bridge returns to idle.
- R9: Synchronous active-high reset puts the bridge in idle with `rxReady`=1, `busCyc`=0, `busStb`=0 and `txValid`=0.
- R10: A write frame produces no bytes on the transmit stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxData | input | 8 | Received byte |
| rxValid | input | 1 | Received byte is valid |
| rxReady | output | 1 | Bridge accepts a received byte |
| txData | output | 8 | Byte to transmit |
| txValid | output | 1 | Transmit byte is valid |
| txReady | input | 1 | Transmitter accepts the byte |
| busAdr | output | 32 | Bus word address |
| busDatW | output | 32 | Bus write data |
| busDatR | input | 32 | Bus read data |
| busSel | output | 4 | Byte-lane selects |
| busWe | output | 1 | Write cycle |
| busCyc | output | 1 | Bus cycle in progress |
| busStb | output | 1 | Bus strobe |
| busAck | input | 1 | Bus acknowledge |

## Verification
The bench sends junk command bytes ahead of a valid frame. A parser that treated them as commands would either run stray bus cycles or lose its place in the frame, and then use the wrong address. Multi-word bursts use a full 32-bit base address and a slow acknowledge. These tests expose byte-order swaps, missing address increments, and off-by-one burst counts that add or drop a cycle. A read under irregular transmit back-pressure shows whether a design starts the next bus read before the previous word has been fully sent, or drops a byte while stalled. Zero-length frames show whether a design wrongly runs 256 cycles or hangs.

// File: rtl/serbus_pkg.sv
package serbus_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h01;
  localparam logic [7:0] CMD_READ  = 8'h02;

  typedef enum logic [2:0] {
    S_IDLE, S_LEN, S_ADDR, S_WDAT, S_WBUS, S_RBUS, S_RSEND
  } bstate_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLen;
    logic shiftAddr;
    logic shiftWord;
    logic loadRead;
    logic shiftTx;
    logic advance;
    logic clrByte;
    logic incByte;
  } dpCmd_t;
endpackage

// File: rtl/serbus_dp.sv
module serbus_dp
  import serbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCmd_t            cmd,
  input  logic [7:0]        rxData,
  input  logic [DATA_W-1:0] busDatR,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] dataQ,
  output logic [7:0]        txByte,
  output logic              lastAddrByte,
  output logic              lastDataByte,
  output logic              lenZero,
  output logic              lenLast
);
  localparam int ABYTES = ADDR_W / 8;
  localparam int DBYTES = DATA_W / 8;
  localparam int MAXB   = (ABYTES > DBYTES) ? ABYTES : DBYTES;
  localparam int CNT_W  = (MAXB > 1) ? $clog2(MAXB) : 1;

  logic [CNT_W-1:0] byteCnt;
  logic [LEN_W-1:0] lenQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ   <= '0;
      dataQ   <= '0;
      lenQ    <= '0;
      byteCnt <= '0;
    end else begin
      if (cmd.loadLen)   lenQ  <= LEN_W'(rxData);
      if (cmd.shiftAddr) addrQ <= {addrQ[ADDR_W-9:0], rxData};
      if (cmd.shiftWord) dataQ <= {dataQ[DATA_W-9:0], rxData};
      else if (cmd.loadRead) dataQ <= busDatR;
      else if (cmd.shiftTx)  dataQ <= {dataQ[DATA_W-9:0], 8'h00};
      if (cmd.advance) begin
        addrQ <= addrQ + 1'b1;
        lenQ  <= lenQ - 1'b1;
      end
      if (cmd.clrByte)      byteCnt <= '0;
      else if (cmd.incByte) byteCnt <= byteCnt + 1'b1;
    end
  end

  assign txByte       = dataQ[DATA_W-1 -: 8];
  assign lastAddrByte = (byteCnt == CNT_W'(ABYTES - 1));
  assign lastDataByte = (byteCnt == CNT_W'(DBYTES - 1));
  assign lenZero      = (lenQ == '0);
  assign lenLast      = (lenQ == LEN_W'(1));
endmodule

// File: rtl/serbus_ctrl.sv
module serbus_ctrl
  import serbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] rxData,
  input  logic       rxValid,
  input  logic       txReady,
  input  logic       busAck,
  input  logic       lastAddrByte,
  input  logic       lastDataByte,
  input  logic       lenZero,
  input  logic       lenLast,
  output logic       rxReady,
  output logic       txValid,
  output logic       busCyc,
  output logic       busStb,
  output logic       busWe,
  output dpCmd_t     cmd
);
  bstate_t state, nextState;
  logic    readOp;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      readOp <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && rxValid) readOp <= (rxData == CMD_READ);
    end
  end

  always_comb begin
    nextState = state;
    cmd       = '0;
    rxReady   = 1'b0;
    txValid   = 1'b0;
    busCyc    = 1'b0;
    busStb    = 1'b0;
    busWe     = 1'b0;
    unique case (state)
      S_IDLE: begin
        rxReady = 1'b1;
        if (rxValid && (rxData == CMD_WRITE || rxData == CMD_READ))
          nextState = S_LEN;
      end
      S_LEN: begin
        rxReady = 1'b1;
        if (rxValid) begin
          cmd.loadLen = 1'b1;
          cmd.clrByte = 1'b1;
          nextState   = S_ADDR;
        end
      end
      S_ADDR: begin
        rxReady = 1'b1;
        if (rxValid) begin
          cmd.shiftAddr = 1'b1;
          if (lastAddrByte) begin
            cmd.clrByte = 1'b1;
            nextState   = lenZero ? S_IDLE : (readOp ? S_RBUS : S_WDAT);
          end else begin
            cmd.incByte = 1'b1;
          end
        end
      end
      S_WDAT: begin
        rxReady = 1'b1;
        if (rxValid) begin
          cmd.shiftWord = 1'b1;
          cmd.incByte   = 1'b1;
          if (lastDataByte) nextState = S_WBUS;
        end
      end
      S_WBUS: begin
        busCyc = 1'b1;
        busStb = 1'b1;
        busWe  = 1'b1;
        if (busAck) begin
          cmd.advance = 1'b1;
          nextState   = lenLast ? S_IDLE : S_WDAT;
        end
      end
      S_RBUS: begin
        busCyc = 1'b1;
        busStb = 1'b1;
        if (busAck) begin
          cmd.advance  = 1'b1;
          cmd.loadRead = 1'b1;
          cmd.clrByte  = 1'b1;
          nextState    = S_RSEND;
        end
      end
      S_RSEND: begin
        txValid = 1'b1;
        if (txReady) begin
          cmd.shiftTx = 1'b1;
          cmd.incByte = 1'b1;
          if (lastDataByte) nextState = lenZero ? S_IDLE : S_RBUS;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/serbus_bridge.sv
module serbus_bridge
  import serbus_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rxData,
  input  logic              rxValid,
  output logic              rxReady,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic [ADDR_W-1:0] busAdr,
  output logic [DATA_W-1:0] busDatW,
  input  logic [DATA_W-1:0] busDatR,
  output logic [DATA_W/8-1:0] busSel,
  output logic              busWe,
  output logic              busCyc,
  output logic              busStb,
  input  logic              busAck
);
  dpCmd_t cmd;
  logic   lastAddrByte, lastDataByte, lenZero, lenLast;

  serbus_ctrl u_ctrl (
    .clk(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid),
    .txReady(txReady), .busAck(busAck),
    .lastAddrByte(lastAddrByte), .lastDataByte(lastDataByte),
    .lenZero(lenZero), .lenLast(lenLast),
    .rxReady(rxReady), .txValid(txValid), .busCyc(busCyc),
    .busStb(busStb), .busWe(busWe), .cmd(cmd)
  );

  serbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rst(rst), .cmd(cmd), .rxData(rxData), .busDatR(busDatR),
    .addrQ(busAdr), .dataQ(busDatW), .txByte(txData),
    .lastAddrByte(lastAddrByte), .lastDataByte(lastDataByte),
    .lenZero(lenZero), .lenLast(lenLast)
  );

  assign busSel = '1;
endmodule

// File: rtl/serbus_chk.sv
module serbus_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              rxReady,
  input logic [7:0]        txData,
  input logic              txValid,
  input logic              txReady,
  input logic [ADDR_W-1:0] busAdr,
  input logic [DATA_W-1:0] busDatW,
  input logic              busWe,
  input logic              busCyc,
  input logic              busStb,
  input logic              busAck
);
  // R7
  stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busStb && !busAck |=> busStb && $stable(busAdr) && $stable(busWe) && $stable(busDatW));

  // R7
  stb_release_chk: assert property (@(posedge clk) disable iff (rst)
    busStb && busAck |=> !busStb);

  // R7
  rx_block_chk: assert property (@(posedge clk) disable iff (rst)
    busCyc |-> !rxReady);

  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    txValid && !txReady |=> txValid && $stable(txData));

  // R6
  tx_bus_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(txValid && busCyc));
endmodule

bind serbus_bridge serbus_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .rxReady(rxReady), .txData(txData),
  .txValid(txValid), .txReady(txReady), .busAdr(busAdr),
  .busDatW(busDatW), .busWe(busWe), .busCyc(busCyc),
  .busStb(busStb), .busAck(busAck)
);

// File: tb/sim_serbus_bridge.sv
module sim_serbus_bridge;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rxData = 8'h00;
  logic        rxValid = 1'b0;
  logic        rxReady;
  logic [7:0]  txData;
  logic        txValid;
  logic        txReady = 1'b1;
  logic [31:0] busAdr, busDatW;
  logic [31:0] busDatR = '0;
  logic [3:0]  busSel;
  logic        busWe, busCyc, busStb;
  logic        busAck = 1'b0;

  always #2.5 clk = ~clk;

  serbus_bridge u0 (
    .clk(clk), .rst(rst), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .busAdr(busAdr), .busDatW(busDatW), .busDatR(busDatR), .busSel(busSel),
    .busWe(busWe), .busCyc(busCyc), .busStb(busStb), .busAck(busAck)
  );

  int nTests = 0;
  int nFail  = 0;

  // bus slave model and logs
  logic [31:0] mem [16];
  logic [31:0] logAdr [64];
  logic [31:0] logDat [64];
  logic        logWe  [64];
  logic [3:0]  logSel [64];
  logic [7:0]  txLog  [256];
  int trN = 0, txN = 0, rdAcks = 0, waitC = 0, ackDelay = 0;
  logic r6Bad = 1'b0;
  logic bpOn = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  function automatic logic [31:0] preload(int i);
    return {8'h5A, 8'(i), 8'(~i), 8'(i * 7)};
  endfunction

  initial for (int i = 0; i < 16; i++) mem[i] = preload(i);

  always @(posedge clk) begin
    if (rst) begin
      busAck <= 1'b0;
      waitC  <= 0;
    end else if (busAck) begin
      busAck <= 1'b0;
    end else if (busCyc && busStb) begin
      if (waitC >= ackDelay) begin
        busAck <= 1'b1;
        waitC  <= 0;
        logAdr[trN] <= busAdr;
        logDat[trN] <= busDatW;
        logWe[trN]  <= busWe;
        logSel[trN] <= busSel;
        trN <= trN + 1;
        if (busWe) mem[busAdr[3:0]] <= busDatW;
        else begin
          busDatR <= mem[busAdr[3:0]];
          if (txN != 4 * rdAcks) r6Bad <= 1'b1;
          rdAcks <= rdAcks + 1;
        end
      end else waitC <= waitC + 1;
    end
  end

  always @(posedge clk) begin
    if (!rst && txValid && txReady) begin
      txLog[txN] <= txData;
      txN <= txN + 1;
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    txReady <= bpOn ? (lfsr[0] & lfsr[2]) | lfsr[6] : 1'b1;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    rxData  = b;
    rxValid = 1'b1;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendHdr(input logic [7:0] c, input logic [7:0] n, input logic [31:0] a);
    sendByte(c);
    sendByte(n);
    for (int i = 3; i >= 0; i--) sendByte(a[i*8 +: 8]);
  endtask

  task automatic sendWord(input logic [31:0] w);
    for (int i = 3; i >= 0; i--) sendByte(w[i*8 +: 8]);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectTx(input int start, input logic [31:0] w, input int k, input string tag);
    for (int i = 0; i < 4; i++)
      chk(txLog[start + 4*k + i] == w[(3-i)*8 +: 8], tag,
          32'(txLog[start + 4*k + i]), 32'(w[(3-i)*8 +: 8]));
  endtask

  task automatic testReset();
    chk(rxReady == 1'b1, "R9 rxReady", 32'(rxReady), 1);
    chk(busCyc == 1'b0 && busStb == 1'b0, "R9 bus idle", {busCyc, busStb}, 0);
    chk(txValid == 1'b0, "R9 txValid", 32'(txValid), 0);
  endtask

  task automatic testJunk();
    int t0 = trN, x0 = txN;
    sendByte(8'h55);
    sendByte(8'h03);
    sendByte(8'h00);
    settle(10);
    chk(trN == t0 && txN == x0, "R1 junk dropped", 32'(trN - t0 + txN - x0), 0);
    sendHdr(8'h02, 8'd1, 32'h0000_0005);
    settle(40);
    chk(trN == t0 + 1, "R1 read after junk count", 32'(trN - t0), 1);
    chk(logAdr[t0] == 32'h5 && !logWe[t0], "R1 read after junk addr", logAdr[t0], 32'h5);
    chk(txN == x0 + 4, "R5 byte count", 32'(txN - x0), 4);
    expectTx(x0, preload(5), 0, "R5 read bytes msb first");
  endtask

  task automatic testSingleWrite();
    int t0 = trN, x0 = txN;
    sendHdr(8'h01, 8'd1, 32'h0000_0003);
    sendWord(32'hA1B2_C3D4);
    settle(20);
    chk(trN == t0 + 1, "R3 one write cycle", 32'(trN - t0), 1);
    chk(logAdr[t0] == 32'h3, "R2 address", logAdr[t0], 32'h3);
    chk(logDat[t0] == 32'hA1B2_C3D4, "R3 write data", logDat[t0], 32'hA1B2_C3D4);
    chk(logWe[t0] && logSel[t0] == 4'hF, "R3 we and sel", {logWe[t0], logSel[t0]}, 32'h1F);
    chk(txN == x0, "R10 no tx on write", 32'(txN - x0), 0);
  endtask

  task automatic testBurstWrite();
    int t0 = trN, x0 = txN;
    logic [31:0] w [3] = '{32'h0102_0304, 32'hDEAD_BEEF, 32'h8000_0001};
    ackDelay = 3;
    sendHdr(8'h01, 8'd3, 32'h1234_5670);
    for (int k = 0; k < 3; k++) sendWord(w[k]);
    settle(30);
    chk(trN == t0 + 3, "R4 burst count", 32'(trN - t0), 3);
    for (int k = 0; k < 3; k++) begin
      chk(logAdr[t0+k] == 32'h1234_5670 + 32'(k), "R4 burst addr", logAdr[t0+k], 32'h1234_5670 + 32'(k));
      chk(logDat[t0+k] == w[k], "R3 burst data", logDat[t0+k], w[k]);
    end
    chk(txN == x0, "R10 no tx on burst write", 32'(txN - x0), 0);
    ackDelay = 0;
  endtask

  task automatic testBurstRead();
    int t0 = trN, x0 = txN;
    logic [31:0] e [4] = '{32'h0102_0304, 32'hDEAD_BEEF, 32'h8000_0001, 32'hA1B2_C3D4};
    sendHdr(8'h02, 8'd4, 32'h0000_0000);
    settle(80);
    chk(trN == t0 + 4, "R4 read burst count", 32'(trN - t0), 4);
    chk(logAdr[t0+3] == 32'h3 && !logWe[t0+3], "R4 read last addr", logAdr[t0+3], 32'h3);
    chk(txN == x0 + 16, "R5 read byte count", 32'(txN - x0), 16);
    for (int k = 0; k < 4; k++) expectTx(x0, e[k], k, "R5 read burst bytes");
  endtask

  task automatic testBackPressure();
    int t0 = trN, x0 = txN;
    ackDelay = 2;
    bpOn = 1'b1;
    sendHdr(8'h02, 8'd3, 32'h0000_000D);
    settle(300);
    bpOn = 1'b0;
    ackDelay = 0;
    settle(4);
    chk(trN == t0 + 3, "R6 read cycles", 32'(trN - t0), 3);
    chk(txN == x0 + 12, "R6 no byte lost", 32'(txN - x0), 12);
    for (int k = 0; k < 3; k++) expectTx(x0, preload(13 + k), k, "R6 bytes under stall");
    chk(!r6Bad, "R6 next read after word sent", 32'(r6Bad), 0);
  endtask

  task automatic testZeroLen();
    int t0 = trN, x0 = txN;
    sendHdr(8'h01, 8'd0, 32'h0000_0004);
    sendHdr(8'h02, 8'd0, 32'h0000_0004);
    settle(20);
    chk(trN == t0 && txN == x0, "R8 zero length idle", 32'(trN - t0 + txN - x0), 0);
    sendHdr(8'h02, 8'd1, 32'h0000_0008);
    settle(30);
    chk(trN == t0 + 1 && logAdr[t0] == 32'h8, "R8 back in idle", logAdr[t0], 32'h8);
    expectTx(x0, preload(8), 0, "R8 following read bytes");
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testJunk();
    testSingleWrite();
    testBurstWrite();
    testBurstRead();
    testBackPressure();
    testZeroLen();
    finish();
  end
endmodule